// File: doc/BRIEF.md
# Dual Card Channel Router

This block sits between one host-side smart card port and two card channels. The host side provides a reset level, a clock and a single data line. Control inputs choose which channel is in session, set per-channel supply-level codes, and pick, per channel, whether the card clock keeps running while that channel is not in session. Each channel's power sequencer reports through `ch_active` when its supply is up. Until then the block holds every card-side control for that channel low.

The selected channel follows the host reset and clock and is linked to the host data line. A channel that is not selected keeps its last reset level, so the card stays initialised and a later switch back needs no new activation. Its I/O link opens and its card-side pull-up turns on. Its clock either stops or keeps running, as set by its clock-run input. The clock gate is retimed so that it only opens or closes while the host clock is low, so no card ever sees a shortened clock pulse. The analog level shifting and the pull-up current sources are outside this block. The data connection appears only as link-enable and pull-up-enable signals.

The host and card clocks are slower signals sampled by the system clock `clk`. The host clock must stay at each level for at least two `clk` cycles. The block has no data stream with flow control, so every pin is a plain level.

Top module: `dual_card_router`

## Requirements
- R1: `io_link[0]` is high only when `sel`=0 and channel 0 is active. `io_link[1]` is high only when `sel`=1 and channel 1 is active. The two are never high together.
- R2: `vlevel[i]` equals `vsel[i]` for every channel, independently of `sel`. Code 1 means the 3V level and code 0 means the 1.8V level. This holds for all eight combinations of `sel` and `vsel`.
- R3: For the selected, active channel, `card_rst[i]` equals the value `host_rst` had at the previous `clk` edge.
- R4: An active channel that is not selected holds `card_rst[i]` at the level it had when it was deselected, whatever `host_rst` does.
- R5: An active channel that is not selected has `io_link[i]`=0 and `io_pull[i]`=1.
- R6: When an active channel is deselected with `clk_run[i]`=0, `card_clk[i]` is low within two host clock periods and stays low while the channel remains deselected.
- R7: When `clk_run[i]`=1 and the channel is active, `card_clk[i]` follows `host_clk` whether or not the channel is selected.
- R8: `host_pull` is 1 exactly when both bits of `ch_en` are 0.
- R9: While `ch_active[i]`=0, `card_rst[i]`, `card_clk[i]`, `io_link[i]` and `io_pull[i]` are all 0. The held reset level is cleared, so a channel that becomes active again while deselected shows `card_rst[i]`=0.
- R10: `card_clk[i]` is high only while `host_clk` is high. Every high phase of `card_clk[i]` starts and ends with a host clock edge, so no high phase is cut short.
- R11: After `rst_n` is released, with no channel active, all card-side outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Session select: 0 picks channel 0, 1 picks channel 1 |
| host_rst | input | 1 | Reset level from the host |
| host_clk | input | 1 | Card clock from the host, slower than `clk` |
| clk_run | input | 2 | Per channel: 1 keeps the card clock running while deselected |
| vsel | input | 2 | Per channel supply choice: 1 = 3V, 0 = 1.8V |
| ch_en | input | 2 | Per channel enable, as given to the sequencers |
| ch_active | input | 2 | Per channel supply-up status from the sequencers |
| vlevel | output | 2 | Per channel supply-level code sent to the regulators |
| card_rst | output | 2 | Per channel card reset level |
| card_clk | output | 2 | Per channel gated card clock |
| io_link | output | 2 | Per channel enable for the link to the host data line |
| io_pull | output | 2 | Per channel enable for the card-side I/O pull-up |
| host_pull | output | 1 | Enable for the weak pull-up on the host data line |

## Verification
The bench goes after the channel switch. A design that copied `host_rst` into both channels would corrupt the held reset of the idle card. A design that gated the clock straight from `sel` would produce a shortened high pulse, which the bench's phase monitor flags. It also re-activates a channel while that channel is deselected. A design that failed to clear the held reset would show a stale high. Finally, it sweeps every `sel`/`vsel` and enable combination, and the clock-run option in both settings. A design with swapped channel indices or an inverted clock-run sense shows up as a wrong level at a named port.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic {
    VLV_1V8 = 1'b0,
    VLV_3V0 = 1'b1
  } vlevel_e;
endpackage

// File: rtl/dcr_clk_gate.sv
module dcr_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic host_clk,
  input  logic want,
  output logic gated
);
  logic open_q;

  // The gate moves only while host_clk is low, so a high phase is never cut.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (!host_clk) open_q <= want;
  end

  assign gated = host_clk & open_q;
endmodule

// File: rtl/dcr_lane.sv
module dcr_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic host_rst,
  input  logic host_clk,
  input  logic picked,
  input  logic run,
  input  logic active,
  output logic card_rst,
  output logic card_clk,
  output logic io_link,
  output logic io_pull
);
  logic rst_q;
  logic clk_g;
  logic want_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_q <= 1'b0;
    else if (!active) rst_q <= 1'b0;
    else if (picked)  rst_q <= host_rst;
  end

  assign want_clk = active & (picked | run);

  dcr_clk_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_clk (host_clk),
    .want     (want_clk),
    .gated    (clk_g)
  );

  assign card_rst = active & rst_q;
  assign card_clk = active & clk_g;
  assign io_link  = active & picked;
  assign io_pull  = active & ~picked;
endmodule

// File: rtl/dual_card_router.sv
module dual_card_router
  import dcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              host_rst,
  input  logic              host_clk,
  input  logic [NUM_CH-1:0] clk_run,
  input  logic [NUM_CH-1:0] vsel,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_active,
  output logic [NUM_CH-1:0] vlevel,
  output logic [NUM_CH-1:0] card_rst,
  output logic [NUM_CH-1:0] card_clk,
  output logic [NUM_CH-1:0] io_link,
  output logic [NUM_CH-1:0] io_pull,
  output logic              host_pull
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    localparam logic [SEL_W-1:0] MY_ID = SEL_W'(g);
    vlevel_e lv;

    assign lv        = vsel[g] ? VLV_3V0 : VLV_1V8;
    assign vlevel[g] = lv;

    dcr_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_rst (host_rst),
      .host_clk (host_clk),
      .picked   (sel == MY_ID),
      .run      (clk_run[g]),
      .active   (ch_active[g]),
      .card_rst (card_rst[g]),
      .card_clk (card_clk[g]),
      .io_link  (io_link[g]),
      .io_pull  (io_pull[g])
    );
  end

  assign host_pull = ~|ch_en;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
  import dcr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              host_rst,
  input logic              host_clk,
  input logic [NUM_CH-1:0] ch_active,
  input logic [NUM_CH-1:0] card_rst,
  input logic [NUM_CH-1:0] card_clk,
  input logic [NUM_CH-1:0] io_link,
  input logic [NUM_CH-1:0] io_pull
);
  AST_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(io_link) <= 1); // R1

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic ME = (g != 0);

    AST_LINK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      io_link[g] |-> (sel == ME)); // R1
    AST_DESEL_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_active[g] && sel != ME) |-> (io_pull[g] && !io_link[g])); // R5
    AST_RST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_active[g] && sel == ME) ##1 ch_active[g] |-> card_rst[g] == $past(host_rst)); // R3
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_active[g] && sel != ME) ##1 ch_active[g] |-> $stable(card_rst[g])); // R4
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_active[g] |-> !(card_rst[g] || card_clk[g] || io_link[g] || io_pull[g])); // R9
    AST_CLK_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      card_clk[g] |-> host_clk); // R10
  end
endmodule

bind dual_card_router dcr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .host_rst  (host_rst),
  .host_clk  (host_clk),
  .ch_active (ch_active),
  .card_rst  (card_rst),
  .card_clk  (card_clk),
  .io_link   (io_link),
  .io_pull   (io_pull)
);

// File: tb/sim_dual_card_router.sv
`timescale 1ns/1ps
module sim_dual_card_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, host_rst = 1'b0, host_clk = 1'b0;
  logic [1:0] clk_run = 2'b00, vsel = 2'b00, ch_en = 2'b00, ch_active = 2'b00;
  logic [1:0] vlevel, card_rst, card_clk, io_link, io_pull;
  logic       host_pull;

  int checks = 0, failures = 0, cycles = 0;
  bit hc_on = 1'b0;
  int hc_cnt = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  dual_card_router u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .host_rst(host_rst), .host_clk(host_clk),
    .clk_run(clk_run), .vsel(vsel), .ch_en(ch_en), .ch_active(ch_active),
    .vlevel(vlevel), .card_rst(card_rst), .card_clk(card_clk), .io_link(io_link),
    .io_pull(io_pull), .host_pull(host_pull)
  );

  // Host clock: two clk cycles high, two low, changed on falling clk edges.
  always @(negedge clk) begin
    if (hc_on) begin
      hc_cnt <= hc_cnt + 1;
      if (hc_cnt % 2 == 1) host_clk <= ~host_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // R10 monitor: each card clock edge must coincide with a host clock edge.
  logic [1:0] pc = 2'b00;
  logic       ph = 1'b0;
  int         phase_bad = 0;
  always begin
    @(clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      if (card_clk[i] && !host_clk) phase_bad++;
      if (card_clk[i] && !pc[i] && ph) phase_bad++;
      if (!card_clk[i] && pc[i] && host_clk) phase_bad++;
    end
    pc = card_clk;
    ph = host_clk;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    bit seen0, seen1, bad;
    logic [1:0] expc;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R11 reset state
    chk({card_rst, card_clk, io_link, io_pull} == 8'h00, "R11 outputs after reset",
        {card_rst, card_clk, io_link, io_pull}, 0);
    chk(host_pull == 1'b1, "R11 host pull after reset", host_pull, 1);

    // R8 enable sweep
    for (int e = 0; e < 4; e++) begin
      ch_en = 2'(e);
      tick();
      chk(host_pull == (e == 0), "R8 host pull", host_pull, (e == 0));
    end

    // R2 sel/vsel sweep, all eight combinations
    for (int c = 0; c < 8; c++) begin
      sel = c[2]; vsel = c[1:0];
      tick();
      chk(vlevel == 2'(c & 3), "R2 level code", vlevel, c & 3);
    end

    // R9 inactive channels stay low for either selection
    for (int s = 0; s < 2; s++) begin
      sel = s[0]; host_rst = 1'b1; hc_on = 1'b1;
      tick(4);
      chk({card_rst, card_clk, io_link, io_pull} == 8'h00, "R9 inactive outputs",
          {card_rst, card_clk, io_link, io_pull}, 0);
    end

    // Activate both, select channel 0
    ch_en = 2'b11; ch_active = 2'b11; sel = 1'b0; host_rst = 1'b0;
    tick(2);
    chk(io_link == 2'b01, "R1 link with sel=0", io_link, 2'b01);
    chk(io_pull == 2'b10, "R5 pull on deselected channel 1", io_pull, 2'b10);

    // R3 reset follows host reset on channel 0
    for (int k = 0; k < 4; k++) begin
      host_rst = k[0] ^ k[1];
      tick();
      chk(card_rst[0] == host_rst, "R3 selected reset follows", card_rst[0], host_rst);
      chk(card_rst[1] == 1'b0, "R4 idle channel 1 reset held", card_rst[1], 0);
    end

    // R4 hold channel 0 high, switch to channel 1
    host_rst = 1'b1; tick();
    sel = 1'b1; tick();
    chk(io_link == 2'b10, "R1 link with sel=1", io_link, 2'b10);
    chk(io_pull == 2'b01, "R5 pull on deselected channel 0", io_pull, 2'b01);
    for (int k = 0; k < 4; k++) begin
      host_rst = k[0];
      tick();
      chk(card_rst[0] == 1'b1, "R4 deselected reset held high", card_rst[0], 1);
      chk(card_rst[1] == host_rst, "R3 channel 1 follows", card_rst[1], host_rst);
    end

    // R6 clock stops on deselected channel 0 with clock-run off
    clk_run = 2'b00;
    tick(8);
    seen0 = 0; seen1 = 0;
    for (int k = 0; k < 16; k++) begin
      tick();
      if (card_clk[0]) seen0 = 1;
      if (card_clk[1]) seen1 = 1;
    end
    chk(!seen0, "R6 deselected clock stopped", seen0, 0);
    chk(seen1, "R6 selected clock running", seen1, 1);

    // R6 stop latency after a fresh switch: gone within two host periods (8 clk)
    sel = 1'b0;
    tick(10);
    sel = 1'b1;
    tick(8);
    seen0 = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (card_clk[0]) seen0 = 1;
    end
    chk(!seen0, "R6 clock low within two host periods", seen0, 0);

    // R7 clock-run keeps deselected channel 0 clocked
    clk_run = 2'b01;
    tick(6);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      tick();
      if (card_clk[0] != host_clk) bad = 1;
    end
    chk(!bad, "R7 clock-run passes clock", bad, 0);
    clk_run = 2'b10; sel = 1'b0;
    tick(6);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      tick();
      expc = {host_clk, host_clk};
      if (card_clk != expc) bad = 1;
    end
    chk(!bad, "R7 both clocked with run on channel 1", bad, 0);

    // R9 drop channel 0 while deselected, re-activate: held reset cleared
    sel = 1'b1; clk_run = 2'b00; host_rst = 1'b1;
    tick(2);
    sel = 1'b0; tick(2); sel = 1'b1; tick(2);
    chk(card_rst[0] == 1'b1, "R4 held level before drop", card_rst[0], 1);
    ch_active = 2'b10; tick(2);
    chk({card_rst[0], card_clk[0], io_link[0], io_pull[0]} == 4'h0, "R9 dropped channel low",
        {card_rst[0], card_clk[0], io_link[0], io_pull[0]}, 0);
    ch_active = 2'b11; tick(2);
    chk(card_rst[0] == 1'b0, "R9 held reset cleared", card_rst[0], 0);

    chk(phase_bad == 0, "R10 no shortened clock phase", phase_bad, 0);
    finish_run();
  end
endmodule